// File: doc/BRIEF.md
# Filtered External Trigger Detector

This block conditions a set of asynchronous trigger lines that start work in the command queues of a queued converter. Line n serves queue n. Each line first passes through a synchronizer into the system clock domain. A glitch filter then accepts a new level only after that level has stayed stable for a programmable number of cycles. The filter length is a single value that all lines share. The filter runs on every line whatever the queue is configured to do, and the filtered levels are available as outputs.

Each queue has its own trigger mode, start bit and gate polarity. The queue's trigger detector compares successive filtered values. It produces a single-cycle event on a filtered rise or a filtered fall. In level-gated mode it produces a gate that stays high while the filtered level equals the chosen polarity. Detection is armed only when the queue mode is not off. For a single-scan queue, the start bit must also be set.

Top module: `xtrig_cond`

The mode field of queue n is `q_mode[3n+2:3n]`. Bits [1:0] select the trigger kind: 00 off, 01 rising edge, 10 falling edge, 11 level gate. Bit 2 selects the scan type: 1 for continuous, 0 for single-scan.

## Requirements
- R1: Each raw line goes through a two-flop synchronizer. With filter length L, a raw change that is held first appears on `filt_lvl` after the (L+3)th rising clock edge following the change.
- R2: The filter compares the synchronized level with the current filtered level. It accepts a differing level only when that level has been sampled on L+1 consecutive cycles. A differing run of L or fewer cycles leaves `filt_lvl` unchanged. An accepted run appears on `filt_lvl` with the same width it had.
- R3: With filter length 0, the filtered level takes the synchronized level on the very next cycle.
- R4: The filter and `filt_lvl` work the same way in every mode, including off.
- R5: In rising-edge mode, `trig_evt[n]` is high for exactly one cycle, in the cycle in which `filt_lvl[n]` has just gone from 0 to 1.
- R6: In falling-edge mode, `trig_evt[n]` is high for exactly one cycle, in the cycle in which `filt_lvl[n]` has just gone from 1 to 0.
- R7: In level-gate mode, `trig_evt[n]` equals 1 while `filt_lvl[n]` equals `gate_pol[n]`, and 0 otherwise.
- R8: With the kind set to off (00), `trig_evt[n]` stays 0.
- R9: In single-scan mode (bit 2 = 0), `trig_evt[n]` stays 0 while `ss_start[n]` is 0. In continuous mode, `ss_start[n]` has no effect.
- R10: Reset clears the filtered levels, the counters and the events. If a queue is armed in the same cycle in which its filtered level changes, no edge event is reported in that cycle.
- R11: The lines are independent. Activity on one line has no effect on the filtered level or the event of any other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| trig_raw | input | NUM_TRIG | Asynchronous raw trigger lines |
| filt_len | input | CNT_W | Shared filter length L |
| q_mode | input | 3*NUM_TRIG | Per-queue mode fields, 3 bits each |
| ss_start | input | NUM_TRIG | Per-queue single-scan start bits |
| gate_pol | input | NUM_TRIG | Per-queue active level for level-gate mode |
| filt_lvl | output | NUM_TRIG | Filtered trigger levels |
| trig_evt | output | NUM_TRIG | Per-queue edge pulse or level gate |

## Verification
A filter counter that is off by one shows up at once as a shift of the `filt_lvl` edge by one cycle, or as a pulse of width L+1 being dropped or a pulse of width L being passed. A stale copy of the previous filtered value would show as a missing edge pulse, a doubled edge pulse or a mistimed edge pulse. Any of these appears in the first cycle after the (L+3)th clock edge that follows the input change. A wrong arming state shows on `trig_evt` in the cycle in which the mode or start bit changes.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [1:0] {
      TK_OFF   = 2'b00,
      TK_RISE  = 2'b01,
      TK_FALL  = 2'b10,
      TK_LEVEL = 2'b11
   } trig_kind_e;
endpackage

// File: rtl/xtrig_sync.sv
module xtrig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/xtrig_filter.sv
module xtrig_filter #(
   parameter int CNT_W  = 4,
   parameter bit ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_in,
   input  logic [CNT_W-1:0] len,
   output logic             lvl
);
   generate
      if (ENABLE) begin : g_cnt
         logic [CNT_W-1:0] cnt_q;
         logic             lvl_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               lvl_q <= 1'b0;
            end else if (s_in == lvl_q) begin
               cnt_q <= '0;
            end else if (cnt_q >= len) begin
               lvl_q <= s_in;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign lvl = lvl_q;

         AST_FILT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_q != $past(lvl_q)) |-> ($past(s_in) == lvl_q)); // R2
         AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
            (len == '0 && s_in != lvl_q) |=> (lvl_q == $past(s_in))); // R3
      end else begin : g_bypass
         logic lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= s_in;
         end
         assign lvl = lvl_q;
      end
   endgenerate
endmodule

// File: rtl/xtrig_detect.sv
module xtrig_detect
   import xtrig_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lvl,
   input  logic [MODE_W-1:0] mode,
   input  logic              ss_start,
   input  logic              pol,
   output logic              evt
);
   trig_kind_e kind;
   logic       cont;
   logic       active;
   logic       act_q;
   logic       lvl_q;

   assign kind   = trig_kind_e'(mode[1:0]);
   assign cont   = mode[2];
   assign active = (kind != TK_OFF) && (cont || ss_start);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         lvl_q <= 1'b0;
      end else begin
         act_q <= active;
         lvl_q <= lvl;
      end
   end

   always_comb begin
      case (kind)
         TK_RISE:  evt = active && act_q && lvl && !lvl_q;
         TK_FALL:  evt = active && act_q && !lvl && lvl_q;
         TK_LEVEL: evt = active && (lvl == pol);
         default:  evt = 1'b0;
      endcase
   end

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == TK_OFF) |-> !evt); // R8
   AST_SS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cont && !ss_start) |-> !evt); // R9
   AST_RISE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == TK_RISE && evt) |=> !(kind == TK_RISE && evt)); // R5
   AST_FALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == TK_FALL && evt) |=> !(kind == TK_FALL && evt)); // R6
endmodule

// File: rtl/xtrig_cond.sv
module xtrig_cond
   import xtrig_pkg::*;
#(
   parameter int NUM_TRIG    = 6,
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_TRIG-1:0]        trig_raw,
   input  logic [CNT_W-1:0]           filt_len,
   input  logic [NUM_TRIG*MODE_W-1:0] q_mode,
   input  logic [NUM_TRIG-1:0]        ss_start,
   input  logic [NUM_TRIG-1:0]        gate_pol,
   output logic [NUM_TRIG-1:0]        filt_lvl,
   output logic [NUM_TRIG-1:0]        trig_evt
);
   localparam int MODE_BITS = NUM_TRIG * MODE_W;

   initial begin
      assert (NUM_TRIG >= 1 && NUM_TRIG <= 32) else $error("NUM_TRIG out of range");
      assert (CNT_W >= 1 && CNT_W <= 16) else $error("CNT_W out of range");
      assert (SYNC_STAGES >= 2 && SYNC_STAGES <= 4) else $error("SYNC_STAGES out of range");
      assert (MODE_BITS == $bits(q_mode)) else $error("mode width mismatch");
   end

   logic [NUM_TRIG-1:0] sync_lvl;

   genvar ch;
   generate
      for (ch = 0; ch < NUM_TRIG; ch++) begin : g_ch
         xtrig_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (trig_raw[ch]),
            .q    (sync_lvl[ch])
         );

         xtrig_filter #(.CNT_W(CNT_W), .ENABLE(FILTER_EN)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .s_in (sync_lvl[ch]),
            .len  (filt_len),
            .lvl  (filt_lvl[ch])
         );

         xtrig_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (filt_lvl[ch]),
            .mode    (q_mode[ch*MODE_W +: MODE_W]),
            .ss_start(ss_start[ch]),
            .pol     (gate_pol[ch]),
            .evt     (trig_evt[ch])
         );
      end
   endgenerate
endmodule

// File: tb/xtrig_cond_tb.sv
module xtrig_cond_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 6;
   localparam int CW = 4;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [N-1:0]    trig_raw;
   logic [CW-1:0]   filt_len;
   logic [N*3-1:0]  q_mode;
   logic [N-1:0]    ss_start;
   logic [N-1:0]    gate_pol;
   logic [N-1:0]    filt_lvl;
   logic [N-1:0]    trig_evt;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xtrig_cond #(.NUM_TRIG(N), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .trig_raw(trig_raw), .filt_len(filt_len),
      .q_mode(q_mode), .ss_start(ss_start), .gate_pol(gate_pol),
      .filt_lvl(filt_lvl), .trig_evt(trig_evt)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   // kind: 0 off, 1 rise, 2 fall, 3 level; cont: mode bit 2
   task automatic run_pulse(input int ch, input int len, input int w, input int kind,
                            input bit cont, input bit ss, input bit pol);
      bit acc;
      bit armed;
      bit ef;
      bit ee;
      q_mode   = '0;
      ss_start = '0;
      gate_pol = '0;
      filt_len = CW'(len);
      q_mode[ch*3 +: 3] = {cont, 2'(kind)};
      ss_start[ch] = ss;
      gate_pol[ch] = pol;
      tick(4);
      acc   = (w >= len + 1);
      armed = (kind != 0) && (cont || ss);
      trig_raw[ch] = 1'b1;
      for (int i = 0; i < w + len + 7; i++) begin
         @(posedge clk);
         @(negedge clk);
         ef = acc && (i >= 2 + len) && (i < w + 2 + len);
         case (kind)
            1:       ee = armed && acc && (i == 2 + len);
            2:       ee = armed && acc && (i == w + 2 + len);
            3:       ee = armed && (ef == pol);
            default: ee = 1'b0;
         endcase
         chk(kind == 0 ? "R4" : (acc ? "R1" : "R2"), "filt_lvl", filt_lvl[ch], ef);
         if (!armed)
            chk(kind == 0 ? "R8" : "R9", "trig_evt unarmed", trig_evt[ch], 1'b0);
         else if (kind == 1)
            chk("R5", "rise evt", trig_evt[ch], ee);
         else if (kind == 2)
            chk("R6", "fall evt", trig_evt[ch], ee);
         else
            chk("R7", "level gate", trig_evt[ch], ee);
         for (int o = 0; o < N; o++) begin
            if (o != ch) begin
               chk("R11", "other filt", filt_lvl[o], 1'b0);
               chk("R11", "other evt", trig_evt[o], 1'b0);
            end
         end
         if (i == w - 1) trig_raw[ch] = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n    = 1'b0;
      trig_raw = '0;
      filt_len = '0;
      q_mode   = '0;
      ss_start = '0;
      gate_pol = '0;
      tick(3);
      for (int c = 0; c < N; c++) begin
         chk("R10", "reset filt", filt_lvl[c], 1'b0);
         chk("R10", "reset evt", trig_evt[c], 1'b0);
      end
      rst_n = 1'b1;
      tick(2);

      // R1 R2 R3 R5 R6 R7: sweep of filter length, pulse width, kind, polarity
      for (int len = 0; len < 16; len++) begin
         for (int w = 1; w <= len + 3; w++) begin
            for (int m = 0; m < 4; m++) begin
               run_pulse((len + w + m) % N, len, w, (m < 2) ? m + 1 : 3, 1'b1, 1'b0, m[0]);
            end
         end
      end

      // R4 and R8: filter keeps working with the kind off
      run_pulse(1, 2, 5, 0, 1'b1, 1'b0, 1'b0);
      run_pulse(3, 0, 1, 0, 1'b0, 1'b1, 1'b1);
      // R9: single-scan needs its start bit; continuous ignores it
      run_pulse(4, 1, 4, 1, 1'b0, 1'b0, 1'b0);
      run_pulse(4, 1, 4, 1, 1'b0, 1'b1, 1'b0);
      run_pulse(5, 3, 6, 3, 1'b0, 1'b0, 1'b1);
      run_pulse(2, 2, 5, 2, 1'b1, 1'b1, 1'b0);

      // R10: arming in the cycle of a filtered rise reports no edge
      q_mode = '0; ss_start = '0; gate_pol = '0; filt_len = CW'(1);
      tick(4);
      trig_raw[2] = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (i == 3) begin
            chk("R10", "filt risen", filt_lvl[2], 1'b1);
            q_mode[2*3 +: 3] = 3'b101;
            #1;
            chk("R10", "no edge on arming", trig_evt[2], 1'b0);
         end else if (i > 3) begin
            chk("R10", "no late edge", trig_evt[2], 1'b0);
         end
      end
      trig_raw[2] = 1'b0;
      tick(6);
      q_mode = '0;
      tick(2);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule